// File: doc/BRIEF.md
# Critical-Word-First Line Refill Controller

This block refills a single cache line after a miss. It sits between the line storage of a cache and a lower memory that returns a line as a burst of eight 64-bit beats. When a miss is accepted it issues one burst request that names the beat the memory must send first. The beat the processor asked for is passed straight through to the processor in the cycle it arrives, together with a one-cycle restart pulse. The remaining beats are then written into the line while the processor carries on.

Two beat orders are selectable per miss. In wrapped order the memory starts at the requested beat and continues upward modulo eight, so the processor restarts on the first beat. In linear order the memory starts at beat 0, and the requested beat is forwarded whenever it turns up. A per-beat fill mask lets the processor read any beat of the line as soon as that beat has landed, without waiting for the whole line. A read of a beat that has not arrived yet is held with a stall.

The line is declared valid, with a one-cycle completion pulse, only once all eight beats are stored. A second miss offered during a refill is refused. The lower memory is not part of the block. In the bench it is modelled as a responder whose first beat comes 11 cycles after the request, with 2 cycles between later beats.

Top module: `line_refill_ctrl`

## Requirements
- R1: After reset the block is idle: busy, mem_req, restart, done and line_valid are 0, and a read of any beat returns rd_stall=1 and rd_ack=0.
- R2: A miss_req seen while idle raises mem_req in the same cycle. mem_first equals miss_beat when order_mode=0 and equals 0 when order_mode=1. busy is 1 from the next cycle.
- R3: With order_mode=0 (wrapped), the i-th beat returned (i = 0..7) is stored at beat index (miss_beat + i) mod 8.
- R4: With order_mode=1 (linear), the i-th beat returned is stored at beat index i.
- R5: restart is 1 for exactly one cycle per refill. That cycle is the one in which the beat with index miss_beat is presented on mem_data, and fwd_data then equals that beat.
- R6: A read of a beat that has already landed is acknowledged with its stored data while the refill is still running.
- R7: A read of a beat not yet filled gives rd_stall=1 and rd_ack=0. It is acknowledged in the cycle after that beat is presented.
- R8: line_valid rises and done pulses for one cycle in the cycle after the eighth beat is presented, never earlier. busy is 0 in that same cycle.
- R9: A miss_req while busy gives mem_req=0 and changes neither the beat order nor the restart of the refill in progress.
- R10: A mem_valid beat presented while idle writes nothing and raises no restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| order_mode | input | 1 | Beat order for the offered miss: 0 wrapped from the requested beat, 1 linear from beat 0 |
| miss_req | input | 1 | Miss offered this cycle |
| miss_beat | input | 3 | Index of the beat the processor needs |
| busy | output | 1 | A refill is in progress |
| mem_req | output | 1 | Burst request to the lower memory |
| mem_first | output | 3 | Beat index the burst must start with |
| mem_valid | input | 1 | A beat is presented by the lower memory |
| mem_data | input | 64 | Beat payload |
| restart | output | 1 | The requested beat is on fwd_data this cycle |
| fwd_data | output | 64 | Beat forwarded to the processor |
| done | output | 1 | One-cycle pulse when the line is complete |
| line_valid | output | 1 | All beats of the line are stored |
| rd_req | input | 1 | Processor read of one beat of the line |
| rd_beat | input | 3 | Beat index read |
| rd_ack | output | 1 | Read served this cycle |
| rd_stall | output | 1 | Read must wait; beat not filled yet |
| rd_data | output | 64 | Read data |

## Verification
A wrong position counter or start index puts beats in the wrong slots. Every beat carries its arrival rank and its memory index, so a full read-back after each refill shows the misplacement. A restart missing or moved to the wrong cycle shows up within one beat time (2 cycles). A fill mask that is set too early or too late moves the first rd_ack by at least one cycle from the landing cycle plus one. A stale completion flag shows as a done or line_valid transition away from cycle 26 after the request. The sweep covers every requested beat in both orders, so an error tied to one index or one order is not masked.

// File: rtl/line_refill_pkg.sv
package line_refill_pkg;
  localparam int unsigned DEF_BEATS     = 8;
  localparam int unsigned DEF_BEAT_BITS = 64;

  typedef enum logic {
    FILL_IDLE   = 1'b0,
    FILL_ACTIVE = 1'b1
  } fill_state_e;
endpackage

// File: rtl/line_refill_seq.sv
// Maps a burst position onto a slot of the line. The position counter is
// added to the start index, so wrapped and linear orders share one adder.
// The number of beats is a power of two, so the wrap is the natural overflow.
module line_refill_seq #(
  parameter int unsigned IDX_W = 3
) (
  input  logic [IDX_W-1:0] start_idx,
  input  logic [IDX_W-1:0] pos,
  input  logic [IDX_W-1:0] crit_idx,
  output logic [IDX_W-1:0] slot_idx,
  output logic             is_last,
  output logic             is_crit
);
  localparam logic [IDX_W-1:0] LAST_POS = {IDX_W{1'b1}};

  always_comb begin
    slot_idx = start_idx + pos;
    is_last  = (pos == LAST_POS);
    is_crit  = (slot_idx == crit_idx);
  end
endmodule

// File: rtl/line_refill_track.sv
// Per-beat fill mask and the line-complete flag.
module line_refill_track #(
  parameter int unsigned BEATS = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             last_wr,
  output logic [BEATS-1:0] mask,
  output logic             line_ok
);
  logic [BEATS-1:0] mask_d;
  logic             ok_d;
  logic             upd_en;

  assign upd_en = clear || wr_en;

  always_comb begin
    mask_d = mask;
    ok_d   = line_ok;
    if (clear) begin
      mask_d = '0;
      ok_d   = 1'b0;
    end else if (wr_en) begin
      mask_d[wr_idx] = 1'b1;
      if (last_wr) ok_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask    <= '0;
      line_ok <= 1'b0;
    end else if (upd_en) begin
      mask    <= mask_d;
      line_ok <= ok_d;
    end
  end
endmodule

// File: rtl/line_refill_store.sv
// Line data registers, one enable per beat, with a read multiplexer.
module line_refill_store #(
  parameter int unsigned BEATS     = 8,
  parameter int unsigned IDX_W     = 3,
  parameter int unsigned BEAT_BITS = 64
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [BEAT_BITS-1:0] wr_data,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [BEAT_BITS-1:0] rd_data
);
  logic [BEATS-1:0][BEAT_BITS-1:0] beat_flat;

  for (genvar g = 0; g < BEATS; g++) begin : g_beat
    logic                 en;
    logic [BEAT_BITS-1:0] q;
    assign en = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (en) q <= wr_data;
    end
    assign beat_flat[g] = q;
  end

  assign rd_data = beat_flat[rd_idx];
endmodule

// File: rtl/line_refill_ctrl.sv
module line_refill_ctrl
  import line_refill_pkg::*;
#(
  parameter  int unsigned BEATS     = DEF_BEATS,
  parameter  int unsigned BEAT_BITS = DEF_BEAT_BITS,
  localparam int unsigned IDX_W     = $clog2(BEATS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 order_mode,
  input  logic                 miss_req,
  input  logic [IDX_W-1:0]     miss_beat,
  output logic                 busy,
  output logic                 mem_req,
  output logic [IDX_W-1:0]     mem_first,
  input  logic                 mem_valid,
  input  logic [BEAT_BITS-1:0] mem_data,
  output logic                 restart,
  output logic [BEAT_BITS-1:0] fwd_data,
  output logic                 done,
  output logic                 line_valid,
  input  logic                 rd_req,
  input  logic [IDX_W-1:0]     rd_beat,
  output logic                 rd_ack,
  output logic                 rd_stall,
  output logic [BEAT_BITS-1:0] rd_data
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_ln;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ln = rst_pipe[1];

  // state
  fill_state_e      state_q, state_d;
  logic [IDX_W-1:0] start_q, start_d;
  logic [IDX_W-1:0] crit_q,  crit_d;
  logic [IDX_W-1:0] pos_q,   pos_d;
  logic             done_q,  done_d;

  logic             accept;
  logic             beat_in;
  logic             ctx_en;
  logic             pos_en;
  logic [IDX_W-1:0] first_idx;
  logic [IDX_W-1:0] slot_idx;
  logic             is_last;
  logic             is_crit;
  logic [BEATS-1:0] fill_mask;

  assign accept    = miss_req && (state_q == FILL_IDLE);
  assign beat_in   = mem_valid && (state_q == FILL_ACTIVE);
  assign first_idx = order_mode ? '0 : miss_beat;
  assign ctx_en    = accept;
  assign pos_en    = accept || beat_in;

  line_refill_seq #(.IDX_W(IDX_W)) u_seq (
    .start_idx (start_q),
    .pos       (pos_q),
    .crit_idx  (crit_q),
    .slot_idx  (slot_idx),
    .is_last   (is_last),
    .is_crit   (is_crit)
  );

  always_comb begin
    state_d = state_q;
    start_d = start_q;
    crit_d  = crit_q;
    pos_d   = pos_q;
    done_d  = 1'b0;
    if (accept) begin
      state_d = FILL_ACTIVE;
      start_d = first_idx;
      crit_d  = miss_beat;
      pos_d   = '0;
    end else if (beat_in) begin
      pos_d = pos_q + 1'b1;
      if (is_last) begin
        state_d = FILL_IDLE;
        done_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      state_q <= FILL_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      start_q <= '0;
      crit_q  <= '0;
    end else if (ctx_en) begin
      start_q <= start_d;
      crit_q  <= crit_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln)     pos_q <= '0;
    else if (pos_en) pos_q <= pos_d;
  end

  line_refill_track #(.BEATS(BEATS), .IDX_W(IDX_W)) u_track (
    .clk     (clk),
    .rst_n   (rst_ln),
    .clear   (accept),
    .wr_en   (beat_in),
    .wr_idx  (slot_idx),
    .last_wr (is_last),
    .mask    (fill_mask),
    .line_ok (line_valid)
  );

  line_refill_store #(.BEATS(BEATS), .IDX_W(IDX_W), .BEAT_BITS(BEAT_BITS)) u_store (
    .clk     (clk),
    .wr_en   (beat_in),
    .wr_idx  (slot_idx),
    .wr_data (mem_data),
    .rd_idx  (rd_beat),
    .rd_data (rd_data)
  );

  // outputs
  assign busy      = (state_q == FILL_ACTIVE);
  assign mem_req   = accept;
  assign mem_first = first_idx;
  assign restart   = beat_in && is_crit;
  assign fwd_data  = mem_data;
  assign done      = done_q;
  assign rd_ack    = rd_req && fill_mask[rd_beat];
  assign rd_stall  = rd_req && !fill_mask[rd_beat];
endmodule

// File: rtl/line_refill_ctrl_chk.sv
module line_refill_ctrl_chk #(
  parameter  int unsigned BEATS = 8,
  localparam int unsigned IDX_W = $clog2(BEATS),
  localparam int unsigned CNT_W = $clog2(BEATS) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             order_mode,
  input logic             busy,
  input logic             mem_req,
  input logic [IDX_W-1:0] mem_first,
  input logic             mem_valid,
  input logic             restart,
  input logic             done,
  input logic             line_valid
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BEATS);

  logic [CNT_W-1:0] beat_cnt;
  logic [CNT_W-1:0] rs_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_cnt <= '0;
      rs_cnt   <= '0;
    end else if (mem_req) begin
      beat_cnt <= '0;
      rs_cnt   <= '0;
    end else begin
      if (mem_valid && busy) beat_cnt <= beat_cnt + 1'b1;
      if (restart)           rs_cnt   <= rs_cnt + 1'b1;
    end
  end

  p_linear_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && order_mode) |-> (mem_first == '0));

  p_one_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rs_cnt == CNT_W'(1)));

  p_restart_in_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> (busy && mem_valid));

  p_all_beats_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (beat_cnt == FULL));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_valid_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_valid) |-> (done && !busy));

  p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !mem_req);
endmodule

bind line_refill_ctrl line_refill_ctrl_chk #(.BEATS(BEATS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .order_mode (order_mode),
  .busy       (busy),
  .mem_req    (mem_req),
  .mem_first  (mem_first),
  .mem_valid  (mem_valid),
  .restart    (restart),
  .done       (done),
  .line_valid (line_valid)
);

// File: tb/tb_line_refill_ctrl.sv
`timescale 1ns/1ps
module tb_line_refill_ctrl;
  localparam int FIRST_LAT = 11;
  localparam int GAP       = 2;
  localparam int NBEAT     = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        order_mode = 1'b0;
  logic        miss_req = 1'b0;
  logic [2:0]  miss_beat = '0;
  logic        busy;
  logic        mem_req;
  logic [2:0]  mem_first;
  logic        mem_valid;
  logic [63:0] mem_data;
  logic        restart;
  logic [63:0] fwd_data;
  logic        done;
  logic        line_valid;
  logic        rd_req = 1'b0;
  logic [2:0]  rd_beat = '0;
  logic        rd_ack;
  logic        rd_stall;
  logic [63:0] rd_data;

  int checks = 0;
  int fails  = 0;
  int seed   = 0;

  always #5 clk = ~clk;

  line_refill_ctrl dut (
    .clk(clk), .rst_n(rst_n), .order_mode(order_mode), .miss_req(miss_req),
    .miss_beat(miss_beat), .busy(busy), .mem_req(mem_req), .mem_first(mem_first),
    .mem_valid(mem_valid), .mem_data(mem_data), .restart(restart), .fwd_data(fwd_data),
    .done(done), .line_valid(line_valid), .rd_req(rd_req), .rd_beat(rd_beat),
    .rd_ack(rd_ack), .rd_stall(rd_stall), .rd_data(rd_data)
  );

  function automatic logic [63:0] word(int s, int k, int idx);
    return {s[31:0], k[7:0], idx[7:0], 16'h5A5A};
  endfunction

  function automatic int slot_of(int c);
    if (c >= FIRST_LAT && c <= FIRST_LAT + GAP*(NBEAT-1) && ((c - FIRST_LAT) % GAP) == 0)
      return (c - FIRST_LAT) / GAP;
    return -1;
  endfunction

  // lower memory model: beat k of a burst is presented in cycle FIRST_LAT+GAP*k
  logic        resp_on = 1'b0;
  int          resp_cyc = 0;
  int          resp_first = 0;
  logic        resp_valid = 1'b0;
  logic [63:0] resp_data = '0;
  logic        inj_valid = 1'b0;
  logic [63:0] inj_data = '0;

  always @(posedge clk) begin
    if (mem_req) begin
      resp_on    <= 1'b1;
      resp_cyc   <= 1;
      resp_first <= int'(mem_first);
      resp_valid <= 1'b0;
    end else if (resp_on) begin
      resp_cyc <= resp_cyc + 1;
      if (slot_of(resp_cyc + 1) >= 0) begin
        resp_valid <= 1'b1;
        resp_data  <= word(seed, slot_of(resp_cyc + 1), (resp_first + slot_of(resp_cyc + 1)) % NBEAT);
      end else begin
        resp_valid <= 1'b0;
      end
      if (resp_cyc + 1 > FIRST_LAT + GAP*(NBEAT-1)) resp_on <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
    end
  end

  assign mem_valid = resp_valid | inj_valid;
  assign mem_data  = inj_valid ? inj_data : resp_data;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic refill(input logic mode, input int beat, input int rbeat, input bit stray);
    int first, exp_pos, rpos, rs_cnt, rs_cyc, ack_cyc, done_cyc;
    logic [63:0] rs_data, ack_data;
    logic stall_seen;
    seed = seed + 1;
    first   = mode ? 0 : beat;
    exp_pos = mode ? beat : 0;
    rpos    = mode ? rbeat : ((rbeat - beat + NBEAT) % NBEAT);
    rs_cnt = 0; rs_cyc = -1; ack_cyc = -1; done_cyc = -1;
    rs_data = '0; ack_data = '0; stall_seen = 1'b0;
    @(negedge clk);
    order_mode = mode; miss_beat = 3'(beat); miss_req = 1'b1;
    #1;
    chk("R2", "mem_req on accept", 64'(mem_req), 64'd1);
    chk("R2", "mem_first", 64'(mem_first), 64'(first));
    if (mode) chk("R4", "linear start", 64'(mem_first), 64'd0);
    for (int n = 1; n <= 30; n++) begin
      @(negedge clk);
      miss_req   = (stray && n == 5);
      order_mode = (stray && n == 5) ? ~mode : mode;
      miss_beat  = (stray && n == 5) ? 3'(beat ^ 1) : 3'(beat);
      if (n == 1) begin rd_req = 1'b1; rd_beat = 3'(rbeat); end
      #1;
      if (stray && n == 5) chk("R9", "mem_req while busy", 64'(mem_req), 64'd0);
      if (n == 1) chk("R2", "busy after accept", 64'(busy), 64'd1);
      if (n == 1) stall_seen = rd_stall && !rd_ack;
      if (restart) begin rs_cnt++; rs_cyc = n; rs_data = fwd_data; end
      if (rd_ack && ack_cyc < 0) begin ack_cyc = n; ack_data = rd_data; end
      if (done && done_cyc < 0) done_cyc = n;
      if (n == 25) chk("R8", "line_valid before last beat lands", 64'(line_valid), 64'd0);
      if (n == 26) begin
        chk("R8", "line_valid after eighth beat", 64'(line_valid), 64'd1);
        chk("R8", "busy cleared at completion", 64'(busy), 64'd0);
      end
    end
    miss_req = 1'b0;
    rd_req = 1'b0;
    chk("R5", "restart count", 64'(rs_cnt), 64'd1);
    chk("R5", "restart cycle", 64'(rs_cyc), 64'(FIRST_LAT + GAP*exp_pos));
    chk("R5", "forwarded beat", rs_data, word(seed, exp_pos, beat));
    chk("R7", "stall before landing", 64'(stall_seen), 64'd1);
    chk(rpos < NBEAT-1 ? "R6" : "R7", "first ack cycle", 64'(ack_cyc), 64'(FIRST_LAT + GAP*rpos + 1));
    chk("R6", "early read data", ack_data, word(seed, rpos, rbeat));
    chk("R8", "done cycle", 64'(done_cyc), 64'(FIRST_LAT + GAP*(NBEAT-1) + 1));
    @(negedge clk);
    for (int j = 0; j < NBEAT; j++) begin
      rd_req = 1'b1; rd_beat = 3'(j);
      #1;
      chk(mode ? "R4" : "R3", "read-back ack", 64'(rd_ack), 64'd1);
      chk(mode ? "R4" : "R3", "read-back data", rd_data,
          word(seed, mode ? j : ((j - beat + NBEAT) % NBEAT), j));
    end
    rd_req = 1'b0;
  endtask

  task automatic stray_beat(input int last_beat, input logic mode, input int last_miss);
    @(negedge clk);
    inj_valid = 1'b1; inj_data = 64'hDEAD_BEEF_0BAD_F00D;
    #1;
    chk("R10", "restart on idle beat", 64'(restart), 64'd0);
    @(negedge clk);
    inj_valid = 1'b0;
    rd_req = 1'b1; rd_beat = 3'(last_beat);
    #1;
    chk("R10", "line kept valid", 64'(line_valid), 64'd1);
    chk("R10", "stored beat unchanged", rd_data,
        word(seed, mode ? last_beat : ((last_beat - last_miss + NBEAT) % NBEAT), last_beat));
    rd_req = 1'b0;
  endtask

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL R8 watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_req = 1'b1; rd_beat = 3'd0;
    #1;
    chk("R1", "busy", 64'(busy), 64'd0);
    chk("R1", "mem_req", 64'(mem_req), 64'd0);
    chk("R1", "restart", 64'(restart), 64'd0);
    chk("R1", "done", 64'(done), 64'd0);
    chk("R1", "line_valid", 64'(line_valid), 64'd0);
    chk("R1", "rd_stall", 64'(rd_stall), 64'd1);
    chk("R1", "rd_ack", 64'(rd_ack), 64'd0);
    rd_req = 1'b0;
    for (int m = 0; m < 2; m++) begin
      for (int b = 0; b < NBEAT; b++) begin
        refill(m[0], b, (b*3 + m) % NBEAT, b[0]);
        if (b == NBEAT-1) stray_beat(2, m[0], b);
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule